// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block steps a clock synthesizer through a change of its divider settings without software timing every write. A request brings new feedback (M), input (P) and output (S) divider values, and in the fractional build a signed 16-bit fraction K as well. The sequencer compares the request with the values already applied. When only the output divider differs, it rewrites the S field in one cycle and leaves the oscillator running. When any loop-setting value differs, it moves the output onto the bypass path, holds the oscillator in reset while it loads the new dividers, waits out a minimum reset time, releases reset and watches the lock flag for a bounded time. It then either switches the output back to the oscillator or reports a timeout.

Two more commands are handled in idle. A power-down command holds the oscillator in reset. A power-up command releases reset and reuses the same bounded lock wait. All delays are counted in reference-clock cycles through a cycles-per-microsecond parameter. The analog loop is not modelled here, and the lock flag arrives as an input.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request accepted in idle whose M and P (and K in the fractional build) equal the applied values changes only the S field of `div_word` at the next edge, pulses `done` for one cycle, never raises `busy`, and leaves `pll_resetb` and `pll_bypass` unchanged. In the fractional build a difference in K alone starts a full relock.
- R2: `div_word` carries M in bits 21:12, P in bits 9:4 and S in bits 2:0, with all other bits zero. `frac_word` carries K in bits 15:0 in the fractional build and stays zero in the integer build, which ignores `req_kdiv`.
- R3: On a full change, `busy` and `pll_bypass` go high at the accepting edge, `pll_resetb` goes low one edge later, and the new dividers appear in `div_word` and `frac_word` one edge after that.
- R4: The integer build sets `pll_lock_sel` at the accepting edge, so it is high no later than the edge where reset falls. The fractional build never sets it.
- R5: After the new dividers are loaded, `pll_resetb` stays low for exactly HOLD_US*CYC_PER_US cycles before it is released.
- R6: `pll_lock` is looked at only after reset has been released. The first edge after release that sees it high clears `pll_bypass`, pulses `done` and drops `busy`. A lock flag that is already high during the hold does not shorten it.
- R7: If lock has not been seen by LOCK_TIMEOUT_US*CYC_PER_US edges after release, `err_timeout` goes high, `pll_bypass` stays high and `busy` drops. `err_timeout` holds until the next accepted divider request or power-up.
- R8: `busy` is high from the accepting edge until the sequence ends, and `done` is never high together with `busy`. Requests and power commands that arrive while `busy` is high are ignored.
- R9: In idle, `pwr_down` drives `pll_resetb` low and `pll_bypass` high at the next edge and keeps the dividers. Priority in idle is `pwr_down`, then `pwr_up`, then `req_valid`.
- R10: In idle, `pwr_up` drives `pll_resetb` high and raises `busy` at the next edge, then runs the R6/R7 lock wait. A request arriving in the same cycle is dropped.
- R11: After reset, `pll_resetb`, `pll_lock_sel`, `busy`, `done`, `err_timeout`, `div_word` and `frac_word` are all zero and `pll_bypass` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Divider change request strobe |
| req_mdiv | input | 10 | Requested feedback divider M |
| req_pdiv | input | 6 | Requested input divider P |
| req_sdiv | input | 3 | Requested output divider S |
| req_kdiv | input | 16 | Requested fraction K (fractional build) |
| pwr_down | input | 1 | Power-down command strobe |
| pwr_up | input | 1 | Power-up command strobe |
| pll_lock | input | 1 | Lock flag from the oscillator |
| pll_resetb | output | 1 | Active-low oscillator reset |
| pll_bypass | output | 1 | Output taken from the reference path |
| pll_lock_sel | output | 1 | Lock flag source select |
| div_word | output | 32 | Applied M, P and S fields |
| frac_word | output | 32 | Applied K field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Lock wait timed out |

## Verification
The bench holds the lock flag high through the whole reset hold. A design that sampled lock too early would clear bypass and finish before reset is released. It counts the hold and the lock-wait windows cycle by cycle, so an off-by-one in either counter shows up as a wrong count, and it checks that the dividers change one edge after reset falls and not in the same edge. It sends requests, power-down strobes and simultaneous commands while the sequencer is busy or idle, which catches a wrong priority or a sequence that lets a new request through. A K-only change is applied to both builds: the integer one must take the one-cycle S path and the fractional one must relock without touching the lock-select bit.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int M_W   = 10;
  localparam int P_W   = 6;
  localparam int S_W   = 3;
  localparam int K_W   = 16;
  localparam int WORD_W = 32;
  localparam int M_LSB = 12;
  localparam int P_LSB = 4;
  localparam int S_LSB = 0;
  localparam int K_LSB = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_LOAD,
    ST_HOLD,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
    logic [K_W-1:0] k;
  } div_set_t;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (dec & (cnt_q != '0));
    cnt_n  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign zero = (cnt_q == '0);

  AST_TMR_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero); // R5
endmodule

// File: rtl/pll_seq_match.sv
module pll_seq_match
  import pll_seq_pkg::*;
(
  input  logic [M_W-1:0] app_m,
  input  logic [P_W-1:0] app_p,
  input  logic [K_W-1:0] app_k,
  input  logic [M_W-1:0] req_m,
  input  logic [P_W-1:0] req_p,
  input  logic [K_W-1:0] req_k,
  output logic           loop_same
);
  logic m_eq, p_eq, k_eq;

  always_comb begin
    m_eq      = (app_m == req_m);
    p_eq      = (app_p == req_p);
    k_eq      = (app_k == req_k);
    loop_same = m_eq & p_eq & k_eq;
  end
endmodule

// File: rtl/pll_seq_divreg.sv
module pll_seq_divreg
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_full,
  input  div_set_t          full_set,
  input  logic              ld_s,
  input  logic [S_W-1:0]    s_new,
  output logic [M_W-1:0]    app_m,
  output logic [P_W-1:0]    app_p,
  output logic [K_W-1:0]    app_k,
  output logic [WORD_W-1:0] div_word,
  output logic [WORD_W-1:0] frac_word
);
  logic [M_W-1:0] m_q;
  logic [P_W-1:0] p_q;
  logic [S_W-1:0] s_q;
  logic [K_W-1:0] k_q;
  logic [S_W-1:0] s_n;
  logic           s_en;

  always_comb begin
    s_en = ld_full | ld_s;
    s_n  = ld_full ? full_set.s : s_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      p_q <= '0;
      k_q <= '0;
    end else if (ld_full) begin
      m_q <= full_set.m;
      p_q <= full_set.p;
      k_q <= full_set.k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
    end else if (s_en) begin
      s_q <= s_n;
    end
  end

  always_comb begin
    div_word                 = '0;
    div_word[M_LSB +: M_W]   = m_q;
    div_word[P_LSB +: P_W]   = p_q;
    div_word[S_LSB +: S_W]   = s_q;
    frac_word                = '0;
    frac_word[K_LSB +: K_W]  = k_q;
  end

  assign app_m = m_q;
  assign app_p = p_q;
  assign app_k = k_q;

  AST_NO_DOUBLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_full && ld_s)); // R1
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter bit FRAC_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic pwr_down,
  input  logic pwr_up,
  input  logic loop_same,
  input  logic pll_lock,
  input  logic tmr_zero,
  output logic capture,
  output logic ld_s,
  output logic ld_full,
  output logic tmr_load,
  output logic tmr_sel_lock,
  output logic tmr_dec,
  output logic resetb,
  output logic bypass,
  output logic lock_sel,
  output logic busy,
  output logic done,
  output logic err
);
  seq_state_e st_q, st_n;
  logic resetb_q, resetb_n;
  logic bypass_q, bypass_n;
  logic lsel_q, lsel_n;
  logic busy_q, busy_n;
  logic done_q, done_n;
  logic err_q, err_n;

  always_comb begin
    st_n         = st_q;
    resetb_n     = resetb_q;
    bypass_n     = bypass_q;
    lsel_n       = lsel_q;
    busy_n       = busy_q;
    err_n        = err_q;
    done_n       = 1'b0;
    capture      = 1'b0;
    ld_s         = 1'b0;
    ld_full      = 1'b0;
    tmr_load     = 1'b0;
    tmr_sel_lock = 1'b0;
    tmr_dec      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pwr_down) begin
          resetb_n = 1'b0;
          bypass_n = 1'b1;
        end else if (pwr_up) begin
          resetb_n     = 1'b1;
          busy_n       = 1'b1;
          err_n        = 1'b0;
          tmr_load     = 1'b1;
          tmr_sel_lock = 1'b1;
          st_n         = ST_WAIT;
        end else if (req_valid) begin
          err_n = 1'b0;
          if (loop_same) begin
            ld_s   = 1'b1;
            done_n = 1'b1;
          end else begin
            capture  = 1'b1;
            busy_n   = 1'b1;
            bypass_n = 1'b1;
            if (!FRAC_EN) lsel_n = 1'b1;
            st_n     = ST_RST;
          end
        end
      end
      ST_RST: begin
        resetb_n = 1'b0;
        st_n     = ST_LOAD;
      end
      ST_LOAD: begin
        ld_full  = 1'b1;
        tmr_load = 1'b1;
        st_n     = ST_HOLD;
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          resetb_n     = 1'b1;
          tmr_load     = 1'b1;
          tmr_sel_lock = 1'b1;
          st_n         = ST_WAIT;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_WAIT: begin
        if (pll_lock) begin
          bypass_n = 1'b0;
          done_n   = 1'b1;
          busy_n   = 1'b0;
          st_n     = ST_IDLE;
        end else if (tmr_zero) begin
          err_n  = 1'b1;
          busy_n = 1'b0;
          st_n   = ST_IDLE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      resetb_q <= 1'b0;
      bypass_q <= 1'b1;
      lsel_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      resetb_q <= resetb_n;
      bypass_q <= bypass_n;
      lsel_q   <= lsel_n;
      busy_q   <= busy_n;
      done_q   <= done_n;
      err_q    <= err_n;
    end
  end

  assign resetb   = resetb_q;
  assign bypass   = bypass_q;
  assign lock_sel = lsel_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;

  generate
    if (!FRAC_EN) begin : g_lsel_chk
      AST_LSEL_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(resetb_q) && busy_q) |-> lsel_q); // R4
    end
  endgenerate

  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && st_q != ST_WAIT) |=> busy_q); // R8
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CYC_PER_US      = 4,
  parameter int HOLD_US         = 3,
  parameter int LOCK_TIMEOUT_US = 10000,
  parameter bit FRAC_EN         = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [M_W-1:0]    req_mdiv,
  input  logic [P_W-1:0]    req_pdiv,
  input  logic [S_W-1:0]    req_sdiv,
  input  logic [K_W-1:0]    req_kdiv,
  input  logic              pwr_down,
  input  logic              pwr_up,
  input  logic              pll_lock,
  output logic              pll_resetb,
  output logic              pll_bypass,
  output logic              pll_lock_sel,
  output logic [WORD_W-1:0] div_word,
  output logic [WORD_W-1:0] frac_word,
  output logic              busy,
  output logic              done,
  output logic              err_timeout
);
  localparam int HOLD_CYC = HOLD_US * CYC_PER_US;
  localparam int LOCK_CYC = LOCK_TIMEOUT_US * CYC_PER_US;
  localparam int MAX_CYC  = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int TMR_W    = $clog2(MAX_CYC + 1);
  localparam int LOWC_W   = $clog2(HOLD_CYC + 2) + 1;

  div_set_t          req_set;
  div_set_t          pend_q;
  logic [M_W-1:0]    app_m;
  logic [P_W-1:0]    app_p;
  logic [K_W-1:0]    app_k;
  logic              loop_same;
  logic              capture, ld_s, ld_full;
  logic              tmr_load, tmr_sel_lock, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  always_comb begin
    req_set.m = req_mdiv;
    req_set.p = req_pdiv;
    req_set.s = req_sdiv;
    req_set.k = FRAC_EN ? req_kdiv : '0;
    tmr_val   = tmr_sel_lock ? TMR_W'(LOCK_CYC - 1) : TMR_W'(HOLD_CYC - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (capture) begin
      pend_q <= req_set;
    end
  end

  pll_seq_match u_match (
    .app_m     (app_m),
    .app_p     (app_p),
    .app_k     (app_k),
    .req_m     (req_set.m),
    .req_p     (req_set.p),
    .req_k     (req_set.k),
    .loop_same (loop_same)
  );

  pll_seq_divreg u_divreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_full   (ld_full),
    .full_set  (pend_q),
    .ld_s      (ld_s),
    .s_new     (req_set.s),
    .app_m     (app_m),
    .app_p     (app_p),
    .app_k     (app_k),
    .div_word  (div_word),
    .frac_word (frac_word)
  );

  pll_seq_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  pll_seq_ctrl #(.FRAC_EN(FRAC_EN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .pwr_down     (pwr_down),
    .pwr_up       (pwr_up),
    .loop_same    (loop_same),
    .pll_lock     (pll_lock),
    .tmr_zero     (tmr_zero),
    .capture      (capture),
    .ld_s         (ld_s),
    .ld_full      (ld_full),
    .tmr_load     (tmr_load),
    .tmr_sel_lock (tmr_sel_lock),
    .tmr_dec      (tmr_dec),
    .resetb       (pll_resetb),
    .bypass       (pll_bypass),
    .lock_sel     (pll_lock_sel),
    .busy         (busy),
    .done         (done),
    .err          (err_timeout)
  );

  // Consecutive cycles with the oscillator reset low, saturating.
  logic [LOWC_W-1:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else if (pll_resetb) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != '1) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  AST_SONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !pwr_down && !pwr_up && loop_same)
      |=> (!busy && done && $stable(pll_resetb) && $stable(pll_bypass))); // R1
  AST_LOAD_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_word[21:4]) || !$stable(frac_word)) |-> !pll_resetb); // R3
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pll_resetb) && $past(busy)) |-> (low_cnt_q >= LOWC_W'(HOLD_CYC))); // R5
  AST_BYPASS_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> ($past(pll_lock) && pll_resetb)); // R6
  AST_TIMEOUT_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (pll_bypass && !busy)); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_PWRDN_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_down) |=> (!pll_resetb && pll_bypass && !busy)); // R9
  AST_PWRUP_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pwr_down && pwr_up) |=> (pll_resetb && busy)); // R10
endmodule

// File: tb/pll_reprog_seq_test.sv
module pll_reprog_seq_test;
  localparam int CPU  = 2;
  localparam int HUS  = 3;
  localparam int TUS  = 10;
  localparam int HCYC = HUS * CPU;
  localparam int LCYC = TUS * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [9:0]  req_m = '0;
  logic [5:0]  req_p = '0;
  logic [2:0]  req_s = '0;
  logic [15:0] req_k = '0;
  logic        pwr_down = 1'b0;
  logic        pwr_up = 1'b0;
  logic        pll_lock = 1'b0;

  logic        resetb, bypass, lsel, busy, done, err;
  logic [31:0] divw, fracw;
  logic        f_resetb, f_bypass, f_lsel, f_busy, f_done, f_err;
  logic [31:0] f_divw, f_fracw;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pll_reprog_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .LOCK_TIMEOUT_US(TUS), .FRAC_EN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mdiv(req_m), .req_pdiv(req_p),
    .req_sdiv(req_s), .req_kdiv(req_k), .pwr_down(pwr_down), .pwr_up(pwr_up), .pll_lock(pll_lock),
    .pll_resetb(resetb), .pll_bypass(bypass), .pll_lock_sel(lsel), .div_word(divw),
    .frac_word(fracw), .busy(busy), .done(done), .err_timeout(err));

  pll_reprog_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .LOCK_TIMEOUT_US(TUS), .FRAC_EN(1'b1)) uut_frac (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mdiv(req_m), .req_pdiv(req_p),
    .req_sdiv(req_s), .req_kdiv(req_k), .pwr_down(pwr_down), .pwr_up(pwr_up), .pll_lock(pll_lock),
    .pll_resetb(f_resetb), .pll_bypass(f_bypass), .pll_lock_sel(f_lsel), .div_word(f_divw),
    .frac_word(f_fracw), .busy(f_busy), .done(f_done), .err_timeout(f_err));

  function automatic logic [31:0] mkdiv(input logic [9:0] m, input logic [5:0] p, input logic [2:0] s);
    return {10'b0, m, 2'b0, p, 1'b0, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Called at a negedge; returns one negedge later with the strobe removed.
  task automatic drive_req(input logic [9:0] m, input logic [5:0] p, input logic [2:0] s, input logic [15:0] k);
    req_m = m; req_p = p; req_s = s; req_k = k; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R11 resetb", {31'b0, resetb}, 0);
    chk("R11 bypass", {31'b0, bypass}, 1);
    chk("R11 lock_sel", {31'b0, lsel}, 0);
    chk("R11 busy/done/err", {29'b0, busy, done, err}, 0);
    chk("R11 div_word", divw, 0);
    chk("R11 frac_word", f_fracw, 0);
  endtask

  task automatic t_power_up_lock();
    pwr_up = 1'b1;
    @(negedge clk);
    pwr_up = 1'b0;
    chk("R10 resetb released", {31'b0, resetb}, 1);
    chk("R10 busy in lock wait", {31'b0, busy}, 1);
    chk("R10 bypass still set", {31'b0, bypass}, 1);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R10 bypass cleared on lock", {31'b0, bypass}, 0);
    chk("R10 done pulse", {30'b0, done, busy}, 2);
    pll_lock = 1'b0;
    @(negedge clk);
    chk("R6 done one cycle", {31'b0, done}, 0);
  endtask

  task automatic t_full_change();
    int cnt;
    drive_req(10'd50, 6'd3, 3'd2, 16'h0);
    chk("R3 busy at accept", {31'b0, busy}, 1);
    chk("R3 bypass at accept", {31'b0, bypass}, 1);
    chk("R4 lock_sel at accept", {31'b0, lsel}, 1);
    chk("R4 frac build lock_sel", {31'b0, f_lsel}, 0);
    chk("R3 reset not yet low", {31'b0, resetb}, 1);
    chk("R3 div not yet loaded", divw, 0);
    pll_lock = 1'b1; // already high: must not shorten the hold (R6)
    @(negedge clk);
    chk("R3 reset low before load", {31'b0, resetb}, 0);
    chk("R3 div still old", divw, 0);
    @(negedge clk);
    chk("R2 div_word layout", divw, mkdiv(10'd50, 6'd3, 3'd2));
    chk("R2 integer frac_word zero", fracw, 0);
    cnt = 0;
    while (resetb == 1'b0 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk("R5 reset hold cycles", cnt, HCYC);
    chk("R6 bypass held until after release", {31'b0, bypass}, 1);
    chk("R6 busy at release", {31'b0, busy}, 1);
    @(negedge clk);
    chk("R6 bypass cleared", {31'b0, bypass}, 0);
    chk("R6 done and not busy", {30'b0, done, busy}, 2);
    pll_lock = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sonly();
    drive_req(10'd50, 6'd3, 3'd5, 16'h0);
    chk("R1 S field updated", divw, mkdiv(10'd50, 6'd3, 3'd5));
    chk("R1 done without busy", {30'b0, done, busy}, 2);
    chk("R1 reset and bypass unchanged", {30'b0, resetb, bypass}, 2);
    @(negedge clk);
    chk("R1 still running", {29'b0, resetb, bypass, busy}, 4);
  endtask

  task automatic t_busy_timeout();
    int cnt;
    drive_req(10'd60, 6'd4, 3'd1, 16'h0);
    chk("R8 busy", {31'b0, busy}, 1);
    drive_req(10'd70, 6'd5, 3'd0, 16'h0);
    @(negedge clk);
    chk("R8 second request ignored", divw, mkdiv(10'd60, 6'd4, 3'd1));
    cnt = 0;
    while (resetb == 1'b0 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    pwr_down = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    chk("R8 power-down ignored while busy", {30'b0, resetb, busy}, 3);
    cnt = 1;
    while (err == 1'b0 && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    chk("R7 timeout window", cnt, LCYC);
    chk("R7 bypass kept, not busy", {30'b0, bypass, busy}, 2);
    chk("R7 no done on timeout", {31'b0, done}, 0);
    @(negedge clk);
    chk("R7 error holds", {31'b0, err}, 1);
  endtask

  task automatic t_power_down_priority();
    pwr_down = 1'b1;
    req_m = 10'd90; req_p = 6'd9; req_s = 3'd3; req_valid = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0; req_valid = 1'b0;
    chk("R9 reset low, bypass high", {30'b0, resetb, bypass}, 1);
    chk("R9 request dropped under power-down", divw, mkdiv(10'd60, 6'd4, 3'd1));
    chk("R9 not busy", {31'b0, busy}, 0);
    chk("R7 error not cleared by power-down", {31'b0, err}, 1);
    pwr_up = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    pwr_up = 1'b0; req_valid = 1'b0;
    chk("R10 power-up wins over request", {30'b0, resetb, busy}, 3);
    chk("R7 error cleared by power-up", {31'b0, err}, 0);
    pll_lock = 1'b1;
    @(negedge clk);
    pll_lock = 1'b0;
    chk("R10 locked after power-up", {30'b0, bypass, done}, 1);
    chk("R10 dividers kept", divw, mkdiv(10'd60, 6'd4, 3'd1));
    @(negedge clk);
  endtask

  task automatic t_frac_k_change();
    int cnt;
    drive_req(10'd60, 6'd4, 3'd6, 16'h8001);
    chk("R2 integer ignores K: S path", divw, mkdiv(10'd60, 6'd4, 3'd6));
    chk("R2 integer frac_word zero", fracw, 0);
    chk("R1 K change relocks fractional", {31'b0, f_busy}, 1);
    chk("R4 fractional lock_sel clear", {31'b0, f_lsel}, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 frac_word K field", f_fracw, 32'h0000_8001);
    pll_lock = 1'b1;
    cnt = 0;
    while (f_done == 1'b0 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk("R6 fractional relock done", {30'b0, f_bypass, f_busy}, 0);
    chk("R4 fractional lock_sel stays clear", {31'b0, f_lsel}, 0);
    pll_lock = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_power_up_lock();
    t_full_change();
    t_sonly();
    t_busy_timeout();
    t_power_down_priority();
    t_frac_k_change();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule